// File: doc/BRIEF.md
# Two-Level I/O Address Translator

This block turns an I/O address issued by a device into a physical address. It walks two levels of tables held in system memory. The upper bits of the I/O address pick an entry in a segment table, and each segment is 256 MB. That entry gives the base of a page table, the size of that table and the page size used inside the segment. The page index then picks a page-table entry. The page entry carries the real page number and separate read and write permission bits. The block checks the access type against those bits and replies with either a physical address or a fault code.

Table entries are 64 bits wide and are fetched through a simple single-beat read port. The port holds its address until the memory signals completion. The block serves one request at a time through a small state machine:

- **IDLE** waits for a request.
- **SEG_RD** fetches the segment entry.
- **SEG_CHK** validates that entry and the table bound.
- **PTE_RD** fetches the page entry.
- **PTE_CHK** applies the permission check and forms the address.
- **RESP** presents the result for exactly one cycle.

The transitions are as follows:

- IDLE→RESP is the pass-through path. It is taken when translation is off.
- IDLE→SEG_RD starts a walk.
- SEG_RD→SEG_CHK and PTE_RD→PTE_CHK fire on read completion.
- SEG_CHK→RESP is the segment-fault path. SEG_CHK→PTE_RD continues the walk.
- PTE_CHK→RESP delivers the result.
- RESP→IDLE closes the request.

Translation is active only when both the configuration enable and the table-origin enable are set. Otherwise addresses pass through untouched.

Top module: `io_xlate_walker`

## Requirements
- R1: After reset, req_ready is 1, mem_rd_valid is 0 and rsp_valid is 0.
- R2: When cfg_xlate_on or origin_on is 0 at acceptance, the response appears in the cycle after acceptance with rsp_fault 0 and rsp_pa equal to req_addr zero-extended, and no table read is made.
- R3: The segment entry is read from address (origin_base_pn << 12) + 8 × (req_addr >> 28), and mem_rd_addr stays stable until mem_rd_done.
- R4: A segment entry whose bit 63 (valid) is 0, or whose page-size code in bits 2:0 is even, yields rsp_fault 1 (segment fault) with rsp_pa 0 and no page-table read.
- R5: Bits 11:5 of the segment entry give the page-table size in 4 KB pages minus one, so it holds 512 × (field+1) entries. A page index at or beyond that count yields rsp_fault 1.
- R6: The page entry is read from address (segment entry bits PA_W-1:12 << 12) + 8 × page index. The page index is req_addr bits 27 down to the page shift.
- R7: Page-size codes 1, 3, 5 and 7 select shifts of 12, 16, 20 and 24. On success rsp_pa takes its bits above the shift from page-entry bits PA_W-1:12 (placed at bit 12 and up) and its bits below the shift from req_addr, with rsp_fault 0.
- R8: A write whose page entry has bit 63 clear, or a read whose page entry has bit 62 clear, yields rsp_fault 2 (page fault) with rsp_pa 0.
- R9: A page entry with both bits 63 and 62 clear is unmapped and faults with code 2 for both reads and writes.
- R10: rsp_valid is high for exactly one cycle per request and rsp_id returns the req_id of that request.
- R11: Only one request is in flight: req_ready is 1 only in the idle state, never while a table read or a response is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_xlate_on | input | 1 | Global translation enable |
| origin_on | input | 1 | Segment-table origin enable |
| origin_base_pn | input | PA_W-12 | 4 KB page number of the segment table |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | IOA_W | Device I/O address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_id | input | ID_W | Requester identifier |
| mem_rd_valid | output | 1 | Table entry read requested |
| mem_rd_addr | output | PA_W | Byte address of the 64-bit entry |
| mem_rd_done | input | 1 | Read data valid this cycle |
| mem_rd_data | input | 64 | Fetched table entry |
| rsp_valid | output | 1 | Result valid (one cycle) |
| rsp_pa | output | PA_W | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 segment fault, 2 page fault |
| rsp_id | output | ID_W | Requester identifier of the result |

## Verification
The bench runs a behavioural model of the walk on integer arithmetic. It compares every table-read address and every response against that model, under zero and multi-cycle memory latency.

The corner cases cover the following defects:
- **Page-size selection.** Each of the four page sizes uses a physical page number whose low bits are non-zero. A translator that mis-decoded the size code would mask the wrong bits and return an address off by those bits.
- **Table bound.** Page indices sit just inside and just past the table end, for tables of one and two 4 KB pages. An off-by-one limit would either fault a legal page or read past the table.
- **Segment faults.** An invalid segment, an even size code and an unset segment entry each must fault without a second read. A design that skipped this would issue a stray page-table fetch.
- **Permissions.** Read-only, write-only and unmapped entries are accessed both ways. A swapped or ignored permission bit shows up as a missing or spurious page fault.

// File: rtl/iox_pkg.sv
package iox_pkg;

    localparam int SEG_SHIFT    = 28;
    localparam int TBL_PG_LOG   = 12;
    localparam int ENT_LOG      = 3;
    localparam int ENT_PER_PG_L = TBL_PG_LOG - ENT_LOG;
    localparam int PIDX_W       = SEG_SHIFT - TBL_PG_LOG;

    // segment entry field positions
    localparam int SE_VALID  = 63;
    localparam int SE_SZ_HI  = 11;
    localparam int SE_SZ_LO  = 5;

    // page entry field positions
    localparam int PE_WR = 63;
    localparam int PE_RD = 62;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_SEG  = 2'd1,
        FLT_PAGE = 2'd2
    } iox_fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEG_RD,
        ST_SEG_CHK,
        ST_PTE_RD,
        ST_PTE_CHK,
        ST_RESP
    } iox_state_e;

endpackage

// File: rtl/iox_seg_decode.sv
module iox_seg_decode
    import iox_pkg::*;
#(
    parameter int IOA_W = 32,
    parameter int PA_W  = 42
) (
    input  logic [63:0]      seg_ent,
    input  logic [IOA_W-1:0] io_addr,
    output logic             seg_ok,
    output logic [4:0]       pg_shift,
    output logic [PA_W-1:0]  pte_addr
);

    localparam int SZ_W = SE_SZ_HI - SE_SZ_LO + 1;

    logic [PIDX_W-1:0] pg_idx;
    logic [SZ_W-1:0]   tbl_pages_m1;
    logic              code_ok;
    logic              bound_ok;
    logic [PA_W-1:0]   tbl_base;

    always_comb begin
        // odd codes 1,3,5,7 map to shifts 12,16,20,24
        pg_shift     = 5'd12 + {1'b0, seg_ent[2:1], 2'b00};
        code_ok      = seg_ent[0];
        pg_idx       = PIDX_W'(io_addr[SEG_SHIFT-1:0] >> pg_shift);
        tbl_pages_m1 = seg_ent[SE_SZ_HI:SE_SZ_LO];
        bound_ok     = pg_idx[PIDX_W-1:ENT_PER_PG_L] <= tbl_pages_m1;
        seg_ok       = seg_ent[SE_VALID] && code_ok && bound_ok;
        tbl_base     = {seg_ent[PA_W-1:TBL_PG_LOG], {TBL_PG_LOG{1'b0}}};
        pte_addr     = tbl_base + (PA_W'(pg_idx) << ENT_LOG);
    end

    logic unused_bits;
    assign unused_bits = ^{seg_ent[62:PA_W], seg_ent[4:3], io_addr[IOA_W-1:SEG_SHIFT]};

endmodule

// File: rtl/iox_page_check.sv
module iox_page_check
    import iox_pkg::*;
#(
    parameter int IOA_W = 32,
    parameter int PA_W  = 42
) (
    input  logic [63:0]      pg_ent,
    input  logic             is_write,
    input  logic [IOA_W-1:0] io_addr,
    input  logic [4:0]       pg_shift,
    output logic             perm_ok,
    output logic [PA_W-1:0]  phys_addr
);

    logic [PA_W-1:0] low_mask;
    logic [PA_W-1:0] frame;

    always_comb begin
        low_mask  = (PA_W'(1) << pg_shift) - PA_W'(1);
        frame     = {pg_ent[PA_W-1:TBL_PG_LOG], {TBL_PG_LOG{1'b0}}};
        phys_addr = (frame & ~low_mask) | (PA_W'(io_addr) & low_mask);
        perm_ok   = is_write ? pg_ent[PE_WR] : pg_ent[PE_RD];
    end

    logic unused_bits;
    assign unused_bits = ^{pg_ent[61:PA_W], pg_ent[TBL_PG_LOG-1:0]};

endmodule

// File: rtl/io_xlate_walker.sv
module io_xlate_walker
    import iox_pkg::*;
#(
    parameter int IOA_W = 32,
    parameter int PA_W  = 42,
    parameter int ID_W  = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_xlate_on,
    input  logic               origin_on,
    input  logic [PA_W-13:0]   origin_base_pn,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [IOA_W-1:0]   req_addr,
    input  logic               req_write,
    input  logic [ID_W-1:0]    req_id,
    output logic               mem_rd_valid,
    output logic [PA_W-1:0]    mem_rd_addr,
    input  logic               mem_rd_done,
    input  logic [63:0]        mem_rd_data,
    output logic               rsp_valid,
    output logic [PA_W-1:0]    rsp_pa,
    output logic [1:0]         rsp_fault,
    output logic [ID_W-1:0]    rsp_id
);

    localparam int SEG_W = IOA_W - SEG_SHIFT;

    iox_state_e       state, nxt_state;
    logic [IOA_W-1:0] r_addr;
    logic             r_write;
    logic [ID_W-1:0]  r_id;
    logic [63:0]      r_seg;
    logic [63:0]      r_pte;
    logic [PA_W-1:0]  r_pa;
    iox_fault_e       r_fault;

    logic             bypass;
    logic             seg_ok;
    logic [4:0]       pg_shift;
    logic [PA_W-1:0]  pte_addr;
    logic [PA_W-1:0]  seg_addr;
    logic             perm_ok;
    logic [PA_W-1:0]  xl_pa;

    assign bypass   = !cfg_xlate_on || !origin_on;
    assign seg_addr = {origin_base_pn, {TBL_PG_LOG{1'b0}}}
                    + (PA_W'(r_addr[IOA_W-1:IOA_W-SEG_W]) << ENT_LOG);

    iox_seg_decode #(.IOA_W(IOA_W), .PA_W(PA_W)) u_seg (
        .seg_ent  (r_seg),
        .io_addr  (r_addr),
        .seg_ok   (seg_ok),
        .pg_shift (pg_shift),
        .pte_addr (pte_addr)
    );

    iox_page_check #(.IOA_W(IOA_W), .PA_W(PA_W)) u_pg (
        .pg_ent    (r_pte),
        .is_write  (r_write),
        .io_addr   (r_addr),
        .pg_shift  (pg_shift),
        .perm_ok   (perm_ok),
        .phys_addr (xl_pa)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    // next-state logic
    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE:    if (req_valid) nxt_state = bypass ? ST_RESP : ST_SEG_RD;
            ST_SEG_RD:  if (mem_rd_done) nxt_state = ST_SEG_CHK;
            ST_SEG_CHK: nxt_state = seg_ok ? ST_PTE_RD : ST_RESP;
            ST_PTE_RD:  if (mem_rd_done) nxt_state = ST_PTE_CHK;
            ST_PTE_CHK: nxt_state = ST_RESP;
            ST_RESP:    nxt_state = ST_IDLE;
            default:    nxt_state = ST_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_addr  <= '0;
            r_write <= 1'b0;
            r_id    <= '0;
            r_seg   <= '0;
            r_pte   <= '0;
            r_pa    <= '0;
            r_fault <= FLT_NONE;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    r_addr  <= req_addr;
                    r_write <= req_write;
                    r_id    <= req_id;
                    r_pa    <= PA_W'(req_addr);
                    r_fault <= FLT_NONE;
                end
                ST_SEG_RD: if (mem_rd_done) r_seg <= mem_rd_data;
                ST_SEG_CHK: if (!seg_ok) begin
                    r_pa    <= '0;
                    r_fault <= FLT_SEG;
                end
                ST_PTE_RD: if (mem_rd_done) r_pte <= mem_rd_data;
                ST_PTE_CHK: begin
                    r_pa    <= perm_ok ? xl_pa : '0;
                    r_fault <= perm_ok ? FLT_NONE : FLT_PAGE;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready    = 1'b0;
        mem_rd_valid = 1'b0;
        mem_rd_addr  = seg_addr;
        rsp_valid    = 1'b0;
        unique case (state)
            ST_IDLE:   req_ready = 1'b1;
            ST_SEG_RD: mem_rd_valid = 1'b1;
            ST_PTE_RD: begin
                mem_rd_valid = 1'b1;
                mem_rd_addr  = pte_addr;
            end
            ST_RESP:   rsp_valid = 1'b1;
            default: ;
        endcase
        rsp_pa    = r_pa;
        rsp_fault = r_fault;
        rsp_id    = r_id;
    end

endmodule

// File: rtl/io_xlate_walker_chk.sv
module io_xlate_walker_chk #(
    parameter int IOA_W = 32,
    parameter int PA_W  = 42
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_xlate_on,
    input logic             req_valid,
    input logic             req_ready,
    input logic [IOA_W-1:0] req_addr,
    input logic             mem_rd_valid,
    input logic             mem_rd_done,
    input logic [PA_W-1:0]  mem_rd_addr,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_pa,
    input logic [1:0]       rsp_fault
);

    assert_ready_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_rd_valid && !rsp_valid));

    assert_rsp_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_done) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !cfg_xlate_on) |=>
            (rsp_valid && rsp_fault == 2'd0 && rsp_pa == PA_W'($past(req_addr))));

    assert_fault_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_pa == '0));

    assert_fault_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault != 2'd3));

endmodule

bind io_xlate_walker io_xlate_walker_chk #(.IOA_W(IOA_W), .PA_W(PA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_xlate_on (cfg_xlate_on),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_addr     (req_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_done  (mem_rd_done),
    .mem_rd_addr  (mem_rd_addr),
    .rsp_valid    (rsp_valid),
    .rsp_pa       (rsp_pa),
    .rsp_fault    (rsp_fault)
);

// File: tb/io_xlate_walker_test.sv
`timescale 1ns/1ps
module io_xlate_walker_test;

    localparam int IOA_W = 32;
    localparam int PA_W  = 42;
    localparam int ID_W  = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_xlate_on = 1'b0;
    logic origin_on = 1'b0;
    logic [PA_W-13:0] origin_base_pn = '0;
    logic req_valid = 1'b0;
    logic [IOA_W-1:0] req_addr = '0;
    logic req_write = 1'b0;
    logic [ID_W-1:0] req_id = '0;
    logic mem_rd_done = 1'b0;
    logic [63:0] mem_rd_data = '0;
    logic req_ready, mem_rd_valid, rsp_valid;
    logic [PA_W-1:0] mem_rd_addr, rsp_pa;
    logic [1:0] rsp_fault;
    logic [ID_W-1:0] rsp_id;

    int n_cmp = 0;
    int n_bad = 0;
    int mem_lat = 0;
    logic [63:0] mem [logic [63:0]];

    always #2.5 clk = ~clk;

    io_xlate_walker #(.IOA_W(IOA_W), .PA_W(PA_W), .ID_W(ID_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_xlate_on(cfg_xlate_on), .origin_on(origin_on),
        .origin_base_pn(origin_base_pn), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_id(req_id),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr), .mem_rd_done(mem_rd_done),
        .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
        .rsp_fault(rsp_fault), .rsp_id(rsp_id)
    );

    function automatic logic [63:0] rd(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    function automatic logic [63:0] mk_seg(input bit v, input logic [63:0] ptpn,
                                           input int pages_m1, input int code);
        return {v, 1'b0, 50'(ptpn), 7'(pages_m1), 2'b00, 3'(code)};
    endfunction

    function automatic logic [63:0] mk_pg(input bit w, input bit r, input logic [63:0] pn);
        return {w, r, 1'b1, 2'b11, 47'(pn), 1'b0, 11'h5A5};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // behavioural model of the two-level walk
    task automatic model(input logic [63:0] a, input bit w,
                         output logic [63:0] pa, output int flt,
                         output logic [63:0] sa, output logic [63:0] pta, output int nrd);
        logic [63:0] se, pe, pidx, span, pnmask;
        int code, sh;
        pa = 0; flt = 0; sa = 0; pta = 0; nrd = 0;
        pnmask = (64'd1 << (PA_W - 12)) - 1;
        if (!cfg_xlate_on || !origin_on) begin
            pa = a;
            return;
        end
        sa = 64'(origin_base_pn) * 4096 + (a >> 28) * 8;
        nrd = 1;
        se = rd(sa);
        code = int'(se & 64'd7);
        if (se[63] == 1'b0 || code % 2 == 0) begin
            flt = 1;
            return;
        end
        sh = (code == 1) ? 12 : (code == 3) ? 16 : (code == 5) ? 20 : 24;
        pidx = (a & 64'h0FFF_FFFF) >> sh;
        span = (((se >> 5) & 64'd127) + 1) * 512;
        if (pidx >= span) begin
            flt = 1;
            return;
        end
        pta = ((se >> 12) & pnmask) * 4096 + pidx * 8;
        nrd = 2;
        pe = rd(pta);
        if (!(w ? pe[63] : pe[62])) begin
            flt = 2;
            return;
        end
        pa = ((((pe >> 12) & pnmask) * 4096) >> sh << sh) | (a & ((64'd1 << sh) - 1));
    endtask

    task automatic do_req(input logic [31:0] a, input bit w, input logic [10:0] id,
                          input string tag);
        logic [63:0] e_pa, e_sa, e_pta;
        int e_flt, e_nrd, seen;
        bit got;
        model(64'(a), w, e_pa, e_flt, e_sa, e_pta, e_nrd);
        @(negedge clk);
        req_addr = a; req_write = w; req_id = id; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        seen = 0;
        got = 1'b0;
        for (int c = 0; c < 80 && !got; c++) begin
            if (c > 0) @(negedge clk);
            if (mem_rd_valid) begin
                chk("R11", "req_ready during walk", 64'(req_ready), 64'd0);
                if (mem_rd_done) begin
                    if (seen == 0) chk("R3", "segment entry address", 64'(mem_rd_addr), e_sa);
                    else           chk("R6", "page entry address", 64'(mem_rd_addr), e_pta);
                    seen++;
                end
            end
            if (rsp_valid) begin
                got = 1'b1;
                chk(tag, "rsp_pa", 64'(rsp_pa), e_pa);
                chk(tag, "rsp_fault", 64'(rsp_fault), 64'(e_flt));
                chk("R10", "rsp_id", 64'(rsp_id), 64'(id));
                chk(tag, "table reads", 64'(seen), 64'(e_nrd));
                if (e_nrd == 0) chk("R2", "pass-through latency", 64'(c), 64'd0);
            end
        end
        if (!got) chk(tag, "response seen", 64'd0, 64'd1);
        @(negedge clk);
        chk("R10", "single-cycle response", 64'(rsp_valid), 64'd0);
    endtask

    // memory responder, driven shortly after the rising edge
    initial begin
        int waitc;
        waitc = 0;
        forever begin
            @(posedge clk);
            #1;
            if (mem_rd_valid) begin
                if (waitc >= mem_lat) begin
                    mem_rd_done = 1'b1;
                    mem_rd_data = rd(64'(mem_rd_addr));
                    waitc = 0;
                end else begin
                    mem_rd_done = 1'b0;
                    waitc++;
                end
            end else begin
                mem_rd_done = 1'b0;
                waitc = 0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R11 actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        origin_base_pn = 30'h100;
        mem[64'h100000 + 0*8] = mk_seg(1, 64'h200, 0, 1);
        mem[64'h100000 + 1*8] = mk_seg(1, 64'h300, 0, 3);
        mem[64'h100000 + 2*8] = mk_seg(1, 64'h400, 0, 5);
        mem[64'h100000 + 3*8] = mk_seg(1, 64'h500, 0, 7);
        mem[64'h100000 + 4*8] = mk_seg(0, 64'h200, 0, 1);
        mem[64'h100000 + 5*8] = mk_seg(1, 64'h200, 0, 2);
        mem[64'h100000 + 6*8] = mk_seg(1, 64'h600, 1, 1);
        mem[64'h200000 + 5*8]    = mk_pg(1, 1, 64'hABCDE);
        mem[64'h200000 + 6*8]    = mk_pg(0, 1, 64'h11111);
        mem[64'h200000 + 7*8]    = mk_pg(1, 0, 64'h22222);
        mem[64'h200000 + 8*8]    = mk_pg(0, 0, 64'h33333);
        mem[64'h300000 + 511*8]  = mk_pg(1, 1, 64'h44447);
        mem[64'h400000 + 3*8]    = mk_pg(1, 1, 64'h75555);
        mem[64'h500000 + 15*8]   = mk_pg(1, 1, 64'h3FFF_FFFF);
        mem[64'h600000 + 1023*8] = mk_pg(1, 1, 64'h9999A);

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "req_ready after reset", 64'(req_ready), 64'd1);
        chk("R1", "mem_rd_valid after reset", 64'(mem_rd_valid), 64'd0);
        chk("R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);

        cfg_xlate_on = 1'b0; origin_on = 1'b1;
        do_req(32'hDEAD_BEEF, 1'b0, 11'h005, "R2");
        cfg_xlate_on = 1'b1; origin_on = 1'b0;
        do_req(32'h1234_5678, 1'b1, 11'h006, "R2");
        origin_on = 1'b1;

        do_req(32'h0000_5123, 1'b0, 11'h001, "R7");
        do_req(32'h0000_5FFC, 1'b1, 11'h002, "R7");
        do_req(32'h0000_6ABC, 1'b0, 11'h003, "R7");
        do_req(32'h0000_6ABC, 1'b1, 11'h004, "R8");
        do_req(32'h0000_7010, 1'b1, 11'h007, "R7");
        do_req(32'h0000_7010, 1'b0, 11'h008, "R8");
        do_req(32'h0000_8000, 1'b0, 11'h009, "R9");
        do_req(32'h0000_8000, 1'b1, 11'h00A, "R9");
        do_req(32'h0000_9000, 1'b0, 11'h00B, "R9");
        do_req(32'h11FF_BEEF, 1'b0, 11'h00C, "R7");
        do_req(32'h1200_0000, 1'b0, 11'h00D, "R5");
        do_req(32'h2031_2345, 1'b1, 11'h00E, "R7");
        do_req(32'h3F12_3456, 1'b0, 11'h00F, "R7");
        do_req(32'h4000_0000, 1'b0, 11'h010, "R4");
        do_req(32'h5000_1000, 1'b1, 11'h011, "R4");
        do_req(32'h7000_0000, 1'b0, 11'h012, "R4");
        do_req(32'h603F_F004, 1'b1, 11'h013, "R5");
        do_req(32'h6040_0000, 1'b0, 11'h014, "R5");

        mem_lat = 3;
        do_req(32'h0000_5123, 1'b1, 11'h7FF, "R6");
        do_req(32'h11FF_BEEF, 1'b1, 11'h155, "R6");
        do_req(32'h4000_0000, 1'b0, 11'h2AA, "R4");

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule